// File: doc/BRIEF.md
# Clock Crosspoint with Post Dividers

This block takes four free-running source clocks and gives three divided output clocks. Each output lane has a crosspoint that picks one of the four sources. It can use the source as it is or use its inverted phase. The picked clock then drives a seven-bit post divider. One lane can take the inverted phase of a source that another lane also uses, so the two outputs never switch at the same instant.

Lanes 0 and 1 each have a primary divide value and an alternate divide value. A frequency-select input picks one of the two. That input is brought into each lane's own clock domain through two flops before it is used. Lane 2 has only the primary value and does not look at the select input.

The divide value, the source and the phase are copied into a lane only at the end of its current output period. Each lane also drives an enable bit that shows whether the lane is producing a clock.

Top module: `clkxbar_top`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit and every `clk_oe` bit is 0.
- R2: Lane i takes its clock from `src_clk[code]`, where the two-bit code is `route_sel[2i+1:2i]`. Code 0 to 3 selects source 0 to 3.
- R3: A divide value N in 2..127 gives an output period of N periods of the selected clock. The output is high for floor(N/2) of those periods. Each rising edge of the output falls on an edge of the selected clock.
- R4: A divide value of 1 passes the selected clock through. The output period and high time equal those of the selected clock.
- R5: A divide value of 0 holds the output low and drives the lane's `clk_oe` to 0. Any nonzero divide value drives `clk_oe` to 1.
- R6: In lanes 0 and 1, `fsel` = 0 selects the primary value `div_pri[7i+6:7i]`, and `fsel` = 1 selects the alternate value `div_alt[7i+6:7i]`.
- R7: Lane 2 always uses `div_pri[20:14]`, whatever the level of `fsel`.
- R8: With `phase_inv[i]` = 1, lane i counts falling edges of its source. Its rising edges then fall on the falling edges of the source and never on its rising edges.
- R9: A new source, phase or divide value takes effect only after the current output period is complete, so the period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 4 | The four free-running source clocks |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsel | input | 1 | Frequency select: picks the primary or alternate divide value in lanes 0 and 1 |
| route_sel | input | 6 | Source code for each lane, two bits per lane |
| phase_inv | input | 3 | Per-lane bit that selects the inverted phase of the source |
| div_pri | input | 21 | Primary seven-bit divide value for each lane |
| div_alt | input | 14 | Alternate seven-bit divide value for lanes 0 and 1 |
| clk_out | output | 3 | Divided output clocks |
| clk_oe | output | 3 | Per-lane enable, high while the lane's divide value is nonzero |

## Verification
Each lane's assertions are clocked by that lane's selected clock. They assume that this clock has no pulses narrower than the counter can follow. That holds only if every change to the source, the phase or the divide value reaches the lane at a period boundary.

The stimulus keeps within this assumption in two ways. It changes the control inputs only at instants that are offset from every source edge. After each change it waits long enough for the slowest possible period to finish before it takes measurements.

Measurements use edge timestamps, so the bench never has to count edges on an edge of the clock being counted. The one deliberate change in the middle of a period is made on a lane that has a fixed source and a fixed phase, and only its divide value changes.

// File: rtl/clkxbar_pkg.sv
package clkxbar_pkg;

  localparam int unsigned SRC_COUNT  = 4;
  localparam int unsigned LANE_COUNT = 3;
  localparam int unsigned ALT_LANES  = 2;
  localparam int unsigned DIVW       = 7;

  // Number of selected-clock periods the output stays high.
  function automatic int unsigned high_len(input int unsigned n);
    return n / 2;
  endfunction

  // True on the selected-clock edge that closes an output period.
  function automatic logic at_period_end(input int unsigned cnt, input int unsigned n);
    return (n < 2) || (cnt + 1 == n);
  endfunction

  // Output level after the counter steps to cnt_next.
  function automatic logic level_after(input int unsigned cnt_next, input int unsigned n);
    return cnt_next < high_len(n);
  endfunction

endpackage

// File: rtl/clkxbar_sync2.sv
module clkxbar_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clkxbar_srcmux.sv
module clkxbar_srcmux #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src,
  input  logic [SEL_W-1:0]   sel,
  input  logic               inv,
  output logic               mclk
);
  assign mclk = src[sel] ^ inv;
endmodule

// File: rtl/clkxbar_postdiv.sv
module clkxbar_postdiv
  import clkxbar_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_next,
  output logic             clk_out,
  output logic             clk_oe,
  output logic             period_end,
  output logic [DIV_W-1:0] act_div,
  output logic [DIV_W-1:0] cnt,
  output logic             div_q
);
  logic [DIV_W-1:0] cnt_inc;

  assign cnt_inc    = cnt + 1'b1;
  assign period_end = at_period_end(32'(cnt), 32'(act_div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      cnt     <= '0;
      div_q   <= 1'b0;
    end else if (period_end) begin
      act_div <= div_next;
      cnt     <= '0;
      div_q   <= (32'(div_next) >= 2);
    end else begin
      cnt     <= cnt_inc;
      div_q   <= level_after(32'(cnt_inc), 32'(act_div));
    end
  end

  assign clk_out = (act_div == DIV_W'(1)) ? clk : div_q;
  assign clk_oe  = (act_div != '0);
endmodule

// File: rtl/clkxbar_lane.sv
module clkxbar_lane #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned DIV_W   = 7,
  parameter bit          HAS_ALT = 1'b1
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               rst_n,
  input  logic               fsel,
  input  logic [SEL_W-1:0]   sel_in,
  input  logic               inv_in,
  input  logic [DIV_W-1:0]   div_pri,
  input  logic [DIV_W-1:0]   div_alt,
  output logic               clk_out,
  output logic               clk_oe,
  output logic               mclk,
  output logic               period_end,
  output logic [DIV_W-1:0]   act_div,
  output logic [DIV_W-1:0]   cnt,
  output logic               div_q
);
  logic [SEL_W-1:0] act_sel;
  logic             act_inv;
  logic [DIV_W-1:0] div_next;

  clkxbar_srcmux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src  (src_clk),
    .sel  (act_sel),
    .inv  (act_inv),
    .mclk (mclk)
  );

  generate
    if (HAS_ALT) begin : g_alt
      logic fs_sync;
      clkxbar_sync2 u_fs_sync (
        .clk   (mclk),
        .rst_n (rst_n),
        .d     (fsel),
        .q     (fs_sync)
      );
      assign div_next = fs_sync ? div_alt : div_pri;
    end else begin : g_single
      logic unused_fs;
      assign unused_fs = fsel ^ (^div_alt);
      assign div_next  = div_pri;
    end
  endgenerate

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= '0;
      act_inv <= 1'b0;
    end else if (period_end) begin
      act_sel <= sel_in;
      act_inv <= inv_in;
    end
  end

  clkxbar_postdiv #(.DIV_W(DIV_W)) u_div (
    .clk        (mclk),
    .rst_n      (rst_n),
    .div_next   (div_next),
    .clk_out    (clk_out),
    .clk_oe     (clk_oe),
    .period_end (period_end),
    .act_div    (act_div),
    .cnt        (cnt),
    .div_q      (div_q)
  );
endmodule

// File: rtl/clkxbar_top.sv
module clkxbar_top
  import clkxbar_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter int unsigned NUM_OUT = LANE_COUNT,
  parameter int unsigned NUM_ALT = ALT_LANES,
  parameter int unsigned DIV_W   = DIVW,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       src_clk,
  input  logic                     rst_n,
  input  logic                     fsel,
  input  logic [NUM_OUT*SEL_W-1:0] route_sel,
  input  logic [NUM_OUT-1:0]       phase_inv,
  input  logic [NUM_OUT*DIV_W-1:0] div_pri,
  input  logic [NUM_ALT*DIV_W-1:0] div_alt,
  output logic [NUM_OUT-1:0]       clk_out,
  output logic [NUM_OUT-1:0]       clk_oe
);
  logic [NUM_OUT-1:0]       lane_mclk;
  logic [NUM_OUT-1:0]       lane_end;
  logic [NUM_OUT-1:0]       lane_q;
  logic [NUM_OUT*DIV_W-1:0] lane_div;
  logic [NUM_OUT*DIV_W-1:0] lane_cnt;

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
      logic [DIV_W-1:0] alt_val;
      if (i < NUM_ALT) begin : g_has_alt
        assign alt_val = div_alt[i*DIV_W +: DIV_W];
      end else begin : g_no_alt
        assign alt_val = div_pri[i*DIV_W +: DIV_W];
      end

      clkxbar_lane #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W),
        .DIV_W   (DIV_W),
        .HAS_ALT (i < NUM_ALT)
      ) u_lane (
        .src_clk    (src_clk),
        .rst_n      (rst_n),
        .fsel       (fsel),
        .sel_in     (route_sel[i*SEL_W +: SEL_W]),
        .inv_in     (phase_inv[i]),
        .div_pri    (div_pri[i*DIV_W +: DIV_W]),
        .div_alt    (alt_val),
        .clk_out    (clk_out[i]),
        .clk_oe     (clk_oe[i]),
        .mclk       (lane_mclk[i]),
        .period_end (lane_end[i]),
        .act_div    (lane_div[i*DIV_W +: DIV_W]),
        .cnt        (lane_cnt[i*DIV_W +: DIV_W]),
        .div_q      (lane_q[i])
      );
    end
  endgenerate
endmodule

// File: rtl/clkxbar_chk.sv
module clkxbar_chk #(
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned DIV_W   = 7
) (
  input logic                     rst_n,
  input logic [NUM_OUT-1:0]       lane_mclk,
  input logic [NUM_OUT-1:0]       lane_end,
  input logic [NUM_OUT-1:0]       lane_q,
  input logic [NUM_OUT*DIV_W-1:0] lane_div,
  input logic [NUM_OUT*DIV_W-1:0] lane_cnt,
  input logic [NUM_OUT-1:0]       clk_out
);
  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
      logic [DIV_W-1:0] act;
      logic [DIV_W-1:0] cnt;
      assign act = lane_div[i*DIV_W +: DIV_W];
      assign cnt = lane_cnt[i*DIV_W +: DIV_W];

      // R5
      div_zero_low_chk: assert property (@(posedge lane_mclk[i]) disable iff (!rst_n)
        (act == '0) |-> (clk_out[i] == 1'b0));

      // R3
      cnt_bound_chk: assert property (@(posedge lane_mclk[i]) disable iff (!rst_n)
        (act > DIV_W'(1)) |-> (cnt < act));

      // R9
      cfg_hold_chk: assert property (@(posedge lane_mclk[i]) disable iff (!rst_n)
        !$past(lane_end[i]) |-> $stable(act));

      // R9
      rise_at_end_chk: assert property (@(posedge lane_mclk[i]) disable iff (!rst_n)
        $rose(lane_q[i]) |-> $past(lane_end[i]));
    end
  endgenerate
endmodule

bind clkxbar_top clkxbar_chk #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) u_chk (
  .rst_n     (rst_n),
  .lane_mclk (lane_mclk),
  .lane_end  (lane_end),
  .lane_q    (lane_q),
  .lane_div  (lane_div),
  .lane_cnt  (lane_cnt),
  .clk_out   (clk_out)
);

// File: tb/tb_clkxbar_top.sv
`timescale 1ns/1ps
module tb_clkxbar_top;
  logic [3:0]  src_clk = '0;
  logic        rst_n = 1'b0;
  logic        fsel = 1'b0;
  logic [5:0]  route_sel = '0;
  logic [2:0]  phase_inv = '0;
  logic [20:0] div_pri = '0;
  logic [13:0] div_alt = '0;
  logic [2:0]  clk_out;
  logic [2:0]  clk_oe;

  clkxbar_top dut (
    .src_clk(src_clk), .rst_n(rst_n), .fsel(fsel), .route_sel(route_sel),
    .phase_inv(phase_inv), .div_pri(div_pri), .div_alt(div_alt),
    .clk_out(clk_out), .clk_oe(clk_oe)
  );

  // Source periods: 5 ns (200 MHz), 6 ns, 8 ns, 14 ns
  real src_per [4] = '{5.0, 6.0, 8.0, 14.0};
  always #2.5 src_clk[0] = ~src_clk[0];
  always #3.0 src_clk[1] = ~src_clk[1];
  always #4.0 src_clk[2] = ~src_clk[2];
  always #7.0 src_clk[3] = ~src_clk[3];

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    lane;
    real   per;
    real   hi;
    real   ph;
    real   src;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // Output edge timestamps, one writer
  logic [2:0] prev_out = '0;
  real last_rise [3];
  real last_fall [3];
  real meas_per  [3];
  real meas_hi   [3];
  real meas_t    [3];
  int  meas_cnt  [3] = '{0, 0, 0};
  bit  have_rise [3] = '{0, 0, 0};

  always @(clk_out) begin
    for (int k = 0; k < 3; k++) begin
      if (clk_out[k] && !prev_out[k]) begin
        if (have_rise[k]) begin
          meas_per[k] = $realtime - last_rise[k];
          meas_hi[k]  = last_fall[k] - last_rise[k];
          meas_t[k]   = $realtime;
          meas_cnt[k] = meas_cnt[k] + 1;
        end
        have_rise[k] = 1'b1;
        last_rise[k] = $realtime;
      end else if (!clk_out[k] && prev_out[k]) begin
        last_fall[k] = $realtime;
      end
    end
    prev_out = clk_out;
  end

  function automatic bit near(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic chk(bit ok, string tag, string what, real act, real expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", tag, what, act, expv);
    end
  endtask

  // Driver side: expected item from the requirements
  task automatic push_exp(int lane, int sel, bit inv, int n, string tag);
    exp_t e;
    real p;
    p     = src_per[sel];
    e.lane = lane;
    e.src  = p;
    e.per  = n * p;
    e.hi   = (n == 1) ? p / 2.0 : (n / 2) * p;
    e.ph   = inv ? 0.0 : p / 2.0;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops items, waits for a fresh full period, compares
  initial begin
    forever begin
      exp_t e;
      int   base;
      real  ph;
      wait (exp_q.size() > 0);
      e    = exp_q[0];
      base = meas_cnt[e.lane];
      while (meas_cnt[e.lane] < base + 2) @(posedge src_clk[0]);
      ph = meas_t[e.lane] - e.src * $floor(meas_t[e.lane] / e.src);
      if (ph > e.src - 0.01) ph = ph - e.src;
      chk(near(meas_per[e.lane], e.per), e.tag, $sformatf("lane%0d period", e.lane), meas_per[e.lane], e.per);
      chk(near(meas_hi[e.lane], e.hi), e.tag, $sformatf("lane%0d high", e.lane), meas_hi[e.lane], e.hi);
      chk(near(ph, e.ph), e.tag, $sformatf("lane%0d phase", e.lane), ph, e.ph);
      void'(exp_q.pop_front());
    end
  end

  task automatic realign();
    @(posedge src_clk[0]);
    #0.25;
  endtask

  task automatic set_lane(int lane, int sel, bit inv, int pri, int alt);
    route_sel[lane*2 +: 2] = 2'(sel);
    phase_inv[lane]        = inv;
    div_pri[lane*7 +: 7]   = 7'(pri);
    if (lane < 2) div_alt[lane*7 +: 7] = 7'(alt);
  endtask

  task automatic drain();
    #3000;
    wait (exp_q.size() == 0);
    realign();
  endtask

  initial begin
    real t0;
    real t1;
    #0.25;
    // R1: reset holds everything low even with nonzero settings
    set_lane(0, 1, 0, 5, 7);
    set_lane(1, 2, 0, 2, 127);
    set_lane(2, 3, 0, 1, 0);
    #200;
    chk(clk_out == 3'b000, "R1", "clk_out in reset", real'(clk_out), 0.0);
    chk(clk_oe == 3'b000, "R1", "clk_oe in reset", real'(clk_oe), 0.0);
    rst_n = 1'b1;

    // R2 R3 R4: different sources, fsel low
    #3000;
    chk(clk_oe == 3'b111, "R5", "clk_oe all enabled", real'(clk_oe), 7.0);
    push_exp(0, 1, 0, 5, "R2/R3");
    push_exp(1, 2, 0, 2, "R2/R3");
    push_exp(2, 3, 0, 1, "R4");
    drain();

    // R6 R7: alternate values, lane 2 unaffected
    fsel = 1'b1;
    #3000;
    push_exp(0, 1, 0, 7, "R6");
    push_exp(1, 2, 0, 127, "R6");
    push_exp(2, 3, 0, 1, "R7");
    drain();

    // R8: one source shared, opposite phases
    fsel = 1'b0;
    set_lane(0, 0, 1, 3, 7);
    set_lane(1, 0, 0, 3, 127);
    set_lane(2, 0, 1, 4, 0);
    #3000;
    push_exp(0, 0, 1, 3, "R8");
    push_exp(1, 0, 0, 3, "R8");
    push_exp(2, 0, 1, 4, "R8");
    drain();

    // R5: divide by zero; R4 with inverted passthrough
    set_lane(2, 0, 0, 0, 0);
    set_lane(0, 3, 1, 1, 7);
    #3000;
    begin
      bit seen_high = 1'b0;
      for (int k = 0; k < 100; k++) begin
        #1.0;
        if (clk_out[2]) seen_high = 1'b1;
      end
      chk(!seen_high, "R5", "lane2 output with zero divide", real'(seen_high), 0.0);
      chk(clk_oe[2] == 1'b0, "R5", "lane2 enable with zero divide", real'(clk_oe[2]), 0.0);
    end
    push_exp(0, 3, 1, 1, "R4/R8");
    drain();

    // R9: change mid-period, old period completes first
    set_lane(0, 0, 0, 9, 7);
    #3000;
    @(posedge clk_out[0]);
    t0 = $realtime;
    #10.25;
    div_pri[6:0] = 7'd2;
    @(posedge clk_out[0]);
    t1 = $realtime;
    chk(near(t1 - t0, 45.0), "R9", "period in progress", t1 - t0, 45.0);
    @(posedge clk_out[0]);
    chk(near($realtime - t1, 10.0), "R9", "period after reload", $realtime - t1, 10.0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule